// File: doc/BRIEF.md
# LCD Phase Clock Generator

This block turns a fast input clock into the phase timing of a segment-LCD driver. A power-of-two prescaler first divides the enabled input cycles by 2^P, where P is a 4-bit code from 0 to 15. A second counter then divides the prescaled ticks by an integer N between 16 and 31. The result is one phase tick every N·2^P enabled input cycles. The block also produces a high-drive strobe that opens at every phase tick and stays open for a programmed number of prescaled periods, from 0 to 7. A permanent high-drive setting holds the strobe open all the time.

A clock enable qualifies every input cycle, which lets the block run from a slower time base without a second clock. A run input parks both counters at zero. New prescale and divide settings are taken only while the block is parked or at the moment the divider wraps, so no phase is ever cut short.

Top module: `lcd_phase_clkgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, pre_tick_o, phase_tick_o and hd_strobe_o are all low.
- R2: While running with the clock enable held high, pre_tick_o is a one-cycle strobe that fires once every 2^P cycles, where P is the value of pre_code_i. The first strobe follows the 2^P-th enabled edge after run_i goes high.
- R3: phase_tick_o fires once every (16 + div_code_i) prescaled ticks, so N ranges from 16 to 31. It is always high in the same cycle as a pre_tick_o.
- R4: An edge at which clk_en_i is low does not advance either counter, and no tick follows that edge.
- R5: While run_i is low, both counters return to zero and all three outputs go low one cycle later. A restart then counts from zero.
- R6: A change to pre_code_i or div_code_i made while running takes effect only after the next phase tick. The phase in progress keeps its old length.
- R7: At a phase tick, hd_strobe_o goes high for L prescaled periods of the new phase, where L is the value of pulse_len_i sampled at that tick. An L of 0 gives no strobe.
- R8: While running, hd_strobe_o is high in the cycle after any edge at which hd_perm_i is high, whatever the pulse state.
- R9: All outputs are registered. Each output reflects the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Qualifies each input clock cycle |
| run_i | input | 1 | Counters run while high and are parked at zero while low |
| pre_code_i | input | 4 | Prescale exponent P, giving a factor of 2^P |
| div_code_i | input | 4 | Divider code, giving N = 16 + code |
| pulse_len_i | input | 3 | Length of the high-drive pulse in prescaled periods |
| hd_perm_i | input | 1 | Holds the high-drive strobe on permanently |
| pre_tick_o | output | 1 | One-cycle strobe for each prescaled period |
| phase_tick_o | output | 1 | One-cycle strobe for each LCD phase |
| hd_strobe_o | output | 1 | High-drive window |

## Verification
Every output comes from a register, so each result is due in the cycle right after the edge that sampled its stimulus. At each rising edge the driver evaluates a cycle-count model written from the requirements. The model keeps only the number of enabled edges since the last wrap, the active P and N, and the pulse width, and it pushes one expected triple per edge into a queue. The monitor pops that triple on the following falling edge and compares it with the outputs, so every output is compared exactly one edge after its stimulus. Configuration changes are applied a quarter period after an edge, never on one.

// File: rtl/lcd_clkgen_pkg.sv
package lcd_clkgen_pkg;

    // Registered single-bit flags driven out of the top level
    typedef struct packed {
        logic pre;
        logic phase;
        logic perm;
    } lcd_flags_t;

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clk_en_i,
    input  logic [PRE_W-1:0] pre_code_i,
    output logic             pre_evt_o
);
    localparam int CNT_W = (1 << PRE_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        // Rollover mask: 2^P - 1 (wraps to all ones for the top code)
        mask      = (CNT_W'(1) << pre_code_i) - CNT_W'(1);
        pre_evt_o = run_i && clk_en_i && (cnt_q == mask);
        cnt_d     = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (pre_evt_o) begin
            cnt_d = '0;
        end else if (clk_en_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lcd_phase_divider.sv
module lcd_phase_divider #(
    parameter int DIV_CODE_W = 4,
    parameter int DIV_BASE   = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  run_i,
    input  logic                  pre_evt_i,
    input  logic [DIV_CODE_W-1:0] div_code_i,
    output logic                  wrap_o
);
    localparam int DIV_MAX = DIV_BASE + (1 << DIV_CODE_W) - 1;
    localparam int DCNT_W  = $clog2(DIV_MAX + 1);

    logic [DCNT_W-1:0] cnt_d, cnt_q;
    logic [DCNT_W-1:0] last;

    always_comb begin
        last   = DCNT_W'(DIV_BASE) + DCNT_W'(div_code_i) - DCNT_W'(1);
        wrap_o = pre_evt_i && (cnt_q == last);
        cnt_d  = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (wrap_o) begin
            cnt_d = '0;
        end else if (pre_evt_i) begin
            cnt_d = cnt_q + DCNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lcd_drive_pulse.sv
module lcd_drive_pulse #(
    parameter int PULSE_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               phase_evt_i,
    input  logic               pre_evt_i,
    input  logic [PULSE_W-1:0] pulse_len_i,
    output logic               pulse_on_o
);
    typedef struct packed {
        logic [PULSE_W-1:0] rem;
        logic               on;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (phase_evt_i) begin
            st_d.rem = pulse_len_i;
            st_d.on  = (pulse_len_i != '0);
        end else if (pre_evt_i && (st_q.rem != '0)) begin
            st_d.rem = st_q.rem - PULSE_W'(1);
            st_d.on  = (st_q.rem != PULSE_W'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse_on_o = st_q.on;
endmodule

// File: rtl/lcd_phase_clkgen.sv
module lcd_phase_clkgen
    import lcd_clkgen_pkg::*;
#(
    parameter int PRE_W      = 4,
    parameter int DIV_CODE_W = 4,
    parameter int DIV_BASE   = 16,
    parameter int PULSE_W    = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clk_en_i,
    input  logic                  run_i,
    input  logic [PRE_W-1:0]      pre_code_i,
    input  logic [DIV_CODE_W-1:0] div_code_i,
    input  logic [PULSE_W-1:0]    pulse_len_i,
    input  logic                  hd_perm_i,
    output logic                  pre_tick_o,
    output logic                  phase_tick_o,
    output logic                  hd_strobe_o
);
    typedef struct packed {
        logic [PRE_W-1:0]      pre;
        logic [DIV_CODE_W-1:0] div;
    } cfg_t;

    cfg_t       cfg_d, cfg_q;
    lcd_flags_t flg_d, flg_q;
    logic       pre_evt;
    logic       wrap_evt;
    logic       pulse_on;

    lcd_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .clk_en_i   (clk_en_i),
        .pre_code_i (cfg_q.pre),
        .pre_evt_o  (pre_evt)
    );

    lcd_phase_divider #(.DIV_CODE_W(DIV_CODE_W), .DIV_BASE(DIV_BASE)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .pre_evt_i  (pre_evt),
        .div_code_i (cfg_q.div),
        .wrap_o     (wrap_evt)
    );

    lcd_drive_pulse #(.PULSE_W(PULSE_W)) u_pulse (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run_i),
        .phase_evt_i (wrap_evt),
        .pre_evt_i   (pre_evt),
        .pulse_len_i (pulse_len_i),
        .pulse_on_o  (pulse_on)
    );

    always_comb begin
        cfg_d = cfg_q;
        // Settings are taken while parked or at a divider wrap only
        if (!run_i || wrap_evt) begin
            cfg_d.pre = pre_code_i;
            cfg_d.div = div_code_i;
        end
        flg_d.pre   = pre_evt;
        flg_d.phase = wrap_evt;
        flg_d.perm  = run_i && hd_perm_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
            flg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            flg_q <= flg_d;
        end
    end

    assign pre_tick_o   = flg_q.pre;
    assign phase_tick_o = flg_q.phase;
    assign hd_strobe_o  = flg_q.perm || pulse_on;
endmodule

// File: rtl/lcd_phase_clkgen_chk.sv
module lcd_phase_clkgen_chk #(
    parameter int PULSE_W = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               clk_en_i,
    input logic               run_i,
    input logic [PULSE_W-1:0] pulse_len_i,
    input logic               hd_perm_i,
    input logic               pre_tick_o,
    input logic               phase_tick_o,
    input logic               hd_strobe_o
);
    // R3
    phase_on_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_tick_o |-> pre_tick_o);

    // R5
    parked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!pre_tick_o && !phase_tick_o && !hd_strobe_o));

    // R4
    gated_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !clk_en_i) |=> (!pre_tick_o && !phase_tick_o));

    // R8
    perm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && hd_perm_i) |=> hd_strobe_o);

    // R7
    pulse_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_tick_o && !$past(hd_perm_i)) |-> (hd_strobe_o == ($past(pulse_len_i) != '0)));
endmodule

bind lcd_phase_clkgen lcd_phase_clkgen_chk #(.PULSE_W(PULSE_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clk_en_i     (clk_en_i),
    .run_i        (run_i),
    .pulse_len_i  (pulse_len_i),
    .hd_perm_i    (hd_perm_i),
    .pre_tick_o   (pre_tick_o),
    .phase_tick_o (phase_tick_o),
    .hd_strobe_o  (hd_strobe_o)
);

// File: tb/lcd_phase_clkgen_tb.sv
module lcd_phase_clkgen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       clk_en_i = 1'b1;
    logic       run_i = 1'b0;
    logic [3:0] pre_code_i = '0;
    logic [3:0] div_code_i = '0;
    logic [2:0] pulse_len_i = '0;
    logic       hd_perm_i = 1'b0;
    logic       pre_tick_o, phase_tick_o, hd_strobe_o;

    lcd_phase_clkgen dut_i (.*);

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    typedef struct {
        logic  pre;
        logic  phase;
        logic  strobe;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_tag = "R1";

    // Model state: enabled edges since last wrap, active settings
    int m = 0, pa = 0, da = 16, width = 0;
    bit started = 0;

    task automatic step();
        exp_t e;
        @(posedge clk_i);
        e.pre = 0; e.phase = 0; e.strobe = 0; e.tag = cur_tag;
        if (!rst_ni) begin
            m = 0; pa = 0; da = 16; width = 0; started = 0;
        end else if (!run_i) begin
            m = 0; pa = int'(pre_code_i); da = 16 + int'(div_code_i);
            width = 0; started = 0;
        end else begin
            if (clk_en_i) begin
                m++;
                e.pre   = ((m % (1 << pa)) == 0);
                e.phase = (m == (da << pa));
                if (e.phase) begin
                    m = 0;
                    pa = int'(pre_code_i);
                    da = 16 + int'(div_code_i);
                    width = int'(pulse_len_i) << pa;
                    started = 1;
                end
            end
            e.strobe = hd_perm_i || (started && (m < width));
        end
        sb_q.push_back(e);
        #(CLK_PERIOD / 4);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(negedge clk_i) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if ({pre_tick_o, phase_tick_o, hd_strobe_o} !== {e.pre, e.phase, e.strobe}) begin
                n_bad++;
                $display("FAIL %s at %0t: pre/phase/strobe got %b%b%b expected %b%b%b",
                         e.tag, $time, pre_tick_o, phase_tick_o, hd_strobe_o,
                         e.pre, e.phase, e.strobe);
            end
        end
    end

    initial begin
        // R1: reset holds every output low
        cur_tag = "R1";
        steps(3);
        rst_ni = 1'b1;
        steps(2);

        // R2 R3 R7 R9: fastest prescale, N=16, 3-period pulse
        cur_tag = "R2 R3 R7 R9";
        pre_code_i = 4'd0; div_code_i = 4'd0; pulse_len_i = 3'd3;
        step();
        run_i = 1'b1;
        steps(60);

        // R5 R3 R7: park, then P=2, N=31, longest pulse
        cur_tag = "R5 R3 R7";
        run_i = 1'b0;
        pre_code_i = 4'd2; div_code_i = 4'd15; pulse_len_i = 3'd7;
        steps(2);
        run_i = 1'b1;
        steps(300);

        // R4 R7: gated edges with P=1, N=21 and a zero-length pulse
        cur_tag = "R4 R7";
        run_i = 1'b0;
        pre_code_i = 4'd1; div_code_i = 4'd5; pulse_len_i = 3'd0;
        step();
        run_i = 1'b1;
        for (int i = 0; i < 240; i++) begin
            clk_en_i = (i % 3) != 0;
            step();
        end
        clk_en_i = 1'b1;

        // R6: settings changed mid-phase apply after the next wrap
        cur_tag = "R6";
        run_i = 1'b0;
        pre_code_i = 4'd1; div_code_i = 4'd0; pulse_len_i = 3'd2;
        step();
        run_i = 1'b1;
        steps(10);
        pre_code_i = 4'd3; div_code_i = 4'd2; pulse_len_i = 3'd1;
        steps(500);

        // R8: permanent high drive overrides the pulse window
        cur_tag = "R8";
        hd_perm_i = 1'b1;
        steps(40);
        hd_perm_i = 1'b0;
        steps(120);

        // R5 R2: park mid-phase, restart with P=4, N=16, 1-period pulse
        cur_tag = "R5 R2";
        run_i = 1'b0;
        pre_code_i = 4'd4; div_code_i = 4'd0; pulse_len_i = 3'd1;
        steps(5);
        run_i = 1'b1;
        steps(600);

        step();
        @(negedge clk_i);
        #1;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule